// File: doc/BRIEF.md
# Receive Character Queue with Overrun Detection

This block sits between the receive shifter of a serial port and the processor. Each character the shifter completes is offered for one cycle on `char_valid` / `char_data`. The block stores it in a 16-entry byte queue, or in a single holding byte when queue mode is off. It reports through `data_ready` whether any character is held.

A character that completes while the store is full is dropped and raises the sticky `overrun` flag. The bytes already queued are not touched. The processor pops one byte per `rd_stb` pulse and sees it on `rd_data` one cycle later. Pulsing `lsr_rd` models a read of the line status and clears `overrun`.

Top module: `rx_char_queue`

## Requirements
- R1: After reset, `data_ready` is 0, `overrun` is 0 and `rd_data` is 0.
- R2: Bytes are returned in arrival order. A byte popped by `rd_stb` at a clock edge appears on `rd_data` after that same edge and holds until the next successful pop.
- R3: With `fifo_en`=1, up to 16 bytes are held. `data_ready` is 1 exactly when at least one byte is held.
- R4: A character that arrives while the store is full, with no pop in that cycle, is discarded. The held bytes and their order are unchanged.
- R5: That discarded arrival sets `overrun`. `overrun` stays 1 until `lsr_rd` is pulsed, and an `lsr_rd` in the same cycle as a new overrun leaves it set.
- R6: A pop and an arrival in the same cycle on a full store both take effect, and `overrun` is not set.
- R7: With `fifo_en`=0, the store holds one byte, and the overrun rule of R4 and R5 applies to that single byte.
- R8: `rd_stb` while nothing is held leaves `rd_data` at the last byte returned and does not disturb later ordering.
- R9: A change of `fifo_en` empties the store at the next clock edge; `overrun` is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: 16-byte queue, 0: single holding byte |
| char_valid | input | 1 | One-cycle pulse: a character has completed |
| char_data | input | 8 | The completed character |
| rd_stb | input | 1 | Pop one byte |
| lsr_rd | input | 1 | Line status read; clears the overrun flag |
| rd_data | output | 8 | Last byte popped |
| data_ready | output | 1 | At least one byte held |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The queue is filled with distinct ascending bytes and drained in full. This shows ordering and the 16-byte capacity. A seventeenth character arriving on a full queue is then checked to leave every stored byte in place. The bench also issues simultaneous pops and arrivals on a full queue, which separates the "pop frees a slot first" behaviour from a plain overrun. Pops on an empty store and the single-byte mode, entered and left through a mode change, check the holding-register behaviour and the flush.

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fifo_en,
  input  logic         char_valid,
  input  logic [W-1:0] char_data,
  input  logic         rd_stb,
  input  logic         lsr_rd,
  output logic [W-1:0] rd_data,
  output logic         data_ready,
  output logic         overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLQ = CW'(DEPTH);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          mode_q;

  wire           flush = fifo_en != mode_q;
  wire [CW-1:0]  cap   = mode_q ? FULLQ : CW'(1);
  wire           full  = count == cap;
  wire           pop   = rd_stb && count != '0 && !flush;
  wire           push  = char_valid && (!full || pop) && !flush;
  wire           drop  = char_valid && full && !pop && !flush;

  assign data_ready = count != '0;

  always_ff @(posedge clk) if (push) mem[wptr] <= char_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      mode_q  <= 1'b1;
      rd_data <= '0;
      overrun <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      if (flush) begin
        wptr  <= '0;
        rptr  <= '0;
        count <= '0;
      end else begin
        if (push) wptr <= (wptr == LASTP) ? '0 : wptr + 1'b1;
        if (pop) begin
          rptr    <= (rptr == LASTP) ? '0 : rptr + 1'b1;
          rd_data <= mem[rptr];
        end
        if (push && !pop) count <= count + 1'b1;
        else if (pop && !push) count <= count - 1'b1;
      end
      if (drop) overrun <= 1'b1;
      else if (lsr_rd) overrun <= 1'b0;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLQ);
  p_drop_keeps_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(count) && $stable(wptr) && $stable(rptr));
  p_drop_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);
  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !char_valid |=> !overrun);
  p_swap_on_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full && pop && char_valid && !overrun |=> !overrun && $stable(count));
  p_byte_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q && !flush |-> count <= CW'(1));
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !data_ready |=> $stable(rd_data));
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !data_ready);
endmodule

// File: tb/sim_rx_char_queue.sv
module sim_rx_char_queue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1;
  logic       char_valid = 1'b0;
  logic [7:0] char_data = '0;
  logic       rd_stb = 1'b0;
  logic       lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic       data_ready, overrun;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] model[$];
  logic [7:0] exp_rd = '0;
  bit exp_ovr = 0;

  always #10 clk = ~clk;

  rx_char_queue u0 (.clk, .rst_n, .fifo_en, .char_valid, .char_data,
                    .rd_stb, .lsr_rd, .rd_data, .data_ready, .overrun);

  function automatic int cap();
    return fifo_en ? 16 : 1;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic status(string req);
    chk({req, " data_ready"}, {7'b0, data_ready}, {7'b0, model.size() != 0});
    chk({req, " overrun"}, {7'b0, overrun}, {7'b0, exp_ovr});
  endtask

  task automatic send(logic [7:0] d);
    @(negedge clk);
    char_valid = 1'b1; char_data = d;
    if (model.size() < cap()) model.push_back(d); else exp_ovr = 1;
    @(negedge clk);
    char_valid = 1'b0;
  endtask

  task automatic pop(string req);
    @(negedge clk);
    rd_stb = 1'b1;
    if (model.size() != 0) exp_rd = model.pop_front();
    @(negedge clk);
    rd_stb = 1'b0;
    chk({req, " rd_data"}, rd_data, exp_rd);
  endtask

  task automatic swap(logic [7:0] d);
    @(negedge clk);
    rd_stb = 1'b1; char_valid = 1'b1; char_data = d;
    exp_rd = model.pop_front();
    model.push_back(d);
    @(negedge clk);
    rd_stb = 1'b0; char_valid = 1'b0;
    chk("R6 rd_data", rd_data, exp_rd);
  endtask

  task automatic lsr(bit with_drop);
    @(negedge clk);
    lsr_rd = 1'b1;
    if (with_drop) begin char_valid = 1'b1; char_data = 8'hEE; end
    exp_ovr = with_drop;
    @(negedge clk);
    lsr_rd = 1'b0; char_valid = 1'b0;
  endtask

  task automatic set_mode(bit m);
    @(negedge clk);
    fifo_en = m;
    model.delete();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, 8'h00);
    status("R1");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) send(8'h10 + 8'(i));
    status("R3 full");
    send(8'hAA);
    status("R5 set");
    @(negedge clk); status("R5 sticky");
    for (int i = 0; i < 16; i++) pop("R4 R2");
    status("R3 empty");

    pop("R8 empty");
    send(8'h55);
    pop("R8 after empty");

    lsr(0); status("R5 cleared");

    for (int i = 0; i < 16; i++) send(8'h40 + 8'(i));
    swap(8'h99);
    status("R6");
    send(8'h77);
    lsr(1); status("R5 same-cycle");
    lsr(0);
    for (int i = 0; i < 16; i++) pop("R6 drain");

    send(8'h01);
    set_mode(0);
    status("R9 flush");
    pop("R9 nothing");
    send(8'hC1);
    status("R7 one held");
    send(8'hC2);
    status("R7 overrun");
    pop("R7 keeps first");
    status("R7 empty");
    lsr(0);
    send(8'hC3);
    pop("R7 next");
    set_mode(1);
    status("R9 back");
    send(8'h21); send(8'h22);
    pop("R2"); pop("R2");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule